// File: doc/BRIEF.md
# Runtime-Configurable Path Expression Matcher

This block checks a stream of XML tags against a linear path query such as `//a/b/c//d`. The query is a chain of up to `NSEG` segments. Each segment has a tag name and an axis. A child-axis segment accepts only an element that sits directly inside the element matched by the segment before it. A descendant-axis segment accepts such an element at any depth below that ancestor. The tag names, name lengths, axes and segment count are held in registers inside the block. A configuration port rewrites them while the block runs, so a new query needs no rebuild.

Character-level XML parsing happens upstream. The block receives one token per cycle: the start of an opening tag name, one name character, the end of an opening tag, or a whole closing tag. Each segment compares the incoming name one character at a time against its stored name. At the end of an opening tag, the block computes which segments matched. It then pushes the current enable vector onto a stack, so that the matching closing tag restores the automaton exactly. This handles recursive nesting of tags that share a name.

The outputs are a per-segment local match vector and a global match flag. Both pulse for one cycle after the end-of-opening-tag token. A sticky error flag reports an attempt to open more nested tags than the stack holds.

Top module: `xpath_seg_chain`

## Requirements
- R1: While reset is applied and after it is released, `local_match`, `global_match` and `stack_err` are 0. The segment count is 0, so no segment can match until `cfg_cnt_we` writes a non-zero count.
- R2: Writes on the configuration port change the matching of every tag that starts after them:
  - `cfg_char_we` stores character `cfg_char` at position `cfg_idx` of segment `cfg_seg`.
  - `cfg_hdr_we` stores the name length `cfg_len` and the axis `cfg_axis` of segment `cfg_seg` (0 = child, 1 = descendant).
  - `cfg_cnt_we` sets the number of active segments.
- R3: Token codes on `tok_kind` are 0 = name start, 1 = name character (in `tok_char`), 2 = opening-tag end and 3 = closing tag. A segment's node test passes only when the tag name has exactly the stored length and every character matches. Names may be up to `NAME_LEN` characters long. A length of 0, or a length above `NAME_LEN`, never passes.
- R4: A child-axis segment i > 0 matches only an element whose parent matched segment i-1. A child-axis segment 0 matches only a top-level element.
- R5: Once segment i-1 has matched, a descendant-axis segment i may match any element nested at any depth inside that element. A descendant-axis segment 0 may match at any depth.
- R6: In the cycle after an opening-tag end token, `local_match` bit i is 1 exactly when segment i matched that tag. Segments at or above the configured count never match. In every other cycle `local_match` is 0.
- R7: `global_match` is 1 for one cycle, in the cycle after an opening-tag end token, when the last configured segment (count minus 1) matches that tag.
- R8: Each opening-tag end saves the enable state and each closing tag restores it. After an element closes, matching resumes exactly as before it opened, including when same-name tags are nested recursively.
- R9: Opening a tag when `STACK_DEPTH` tags are already open sets `stack_err`. The flag stays set until reset.
- R10: A closing tag received while no tag is open is ignored and leaves the matching state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| tok_valid | input | 1 | A token is present this cycle |
| tok_kind | input | 2 | Token code (see R3) |
| tok_char | input | CHAR_W | Name character for code 1 |
| cfg_char_we | input | 1 | Write one name character |
| cfg_hdr_we | input | 1 | Write name length and axis |
| cfg_cnt_we | input | 1 | Write the segment count |
| cfg_seg | input | $clog2(NSEG) | Segment selected for a character or header write |
| cfg_idx | input | $clog2(NAME_LEN) | Character position |
| cfg_char | input | CHAR_W | Character value |
| cfg_len | input | $clog2(NAME_LEN+1) | Name length |
| cfg_axis | input | 1 | Axis: 0 child, 1 descendant |
| cfg_cnt | input | $clog2(NSEG+1) | Number of active segments |
| local_match | output | NSEG | Per-segment match pulse |
| global_match | output | 1 | Whole-path match pulse |
| stack_err | output | 1 | Sticky nesting overflow |

## Verification
The assertions check the following on every cycle:
- Match pulses appear only in the cycle after an opening-tag end.
- A global match always comes with a local match.
- No segment beyond the count ever reports a match.
- The stack depth stays in range, an overflowing push leaves it unchanged, and the overflow flag stays set.
- A closing tag at depth zero leaves the enable state unchanged.

Only the bench scenarios can show that the path semantics are right. These include:
- the child axis breaking on an intervening element,
- the descendant axis reaching deep elements,
- recursive same-name nesting restored by closing tags,
- exact-length name comparison at the 16-character limit,
- runtime reconfiguration of names, axes and count.

// File: rtl/xsc_pkg.sv
package xsc_pkg;
  typedef enum logic [1:0] {
    TK_NAME_START = 2'd0,
    TK_NAME_CHAR  = 2'd1,
    TK_OPEN_END   = 2'd2,
    TK_CLOSE      = 2'd3
  } tok_kind_e;

  localparam logic AXIS_CHILD = 1'b0;
  localparam logic AXIS_DESC  = 1'b1;
endpackage

// File: rtl/xsc_node_test.sv
// One segment's node test: stored name, length, axis and a running
// character comparison over the tag name as it streams in.
module xsc_node_test #(
  parameter int NAME_LEN = 16,
  parameter int CHAR_W   = 8,
  localparam int AW      = $clog2(NAME_LEN),
  localparam int IW      = $clog2(NAME_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_char_we,
  input  logic [AW-1:0]     cfg_idx,
  input  logic [CHAR_W-1:0] cfg_char,
  input  logic              cfg_hdr_we,
  input  logic [IW-1:0]     cfg_len,
  input  logic              cfg_axis,
  input  logic              tok_start,
  input  logic              tok_char_v,
  input  logic [CHAR_W-1:0] tok_char,
  input  logic [IW-1:0]     char_idx,
  output logic              name_hit,
  output logic              axis
);
  logic [CHAR_W-1:0] name_mem [NAME_LEN];
  logic [IW-1:0]     len_q, len_d;
  logic              axis_q, axis_d;
  logic              ok_q, ok_d;
  logic [CHAR_W-1:0] rd_char;
  logic              in_range;

  // name storage, no reset (plain memory)
  always_ff @(posedge clk) begin
    if (cfg_char_we) name_mem[cfg_idx] <= cfg_char;
  end

  always_comb begin
    in_range = (char_idx < len_q) && (char_idx < IW'(NAME_LEN));
    rd_char  = (char_idx < IW'(NAME_LEN)) ? name_mem[char_idx[AW-1:0]] : '0;
  end

  always_comb begin
    len_d  = len_q;
    axis_d = axis_q;
    ok_d   = ok_q;
    if (cfg_hdr_we) begin
      len_d  = cfg_len;
      axis_d = cfg_axis;
    end
    if (tok_start) begin
      ok_d = 1'b1;
    end else if (tok_char_v) begin
      ok_d = ok_q & in_range & (rd_char == tok_char);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      axis_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      len_q  <= len_d;
      axis_q <= axis_d;
      ok_q   <= ok_d;
    end
  end

  assign name_hit = ok_q & (char_idx == len_q) & (len_q != '0);
  assign axis     = axis_q;
endmodule

// File: rtl/xsc_tag_stack.sv
// Stack of per-depth enable vectors with sticky overflow flag.
module xsc_tag_stack #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] push_data,
  output logic [WIDTH-1:0] pop_data,
  output logic             full,
  output logic             empty,
  output logic             overflow
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [DW-1:0]    depth_q, depth_d;
  logic             err_q, err_d;

  assign full     = (depth_q == DW'(DEPTH));
  assign empty    = (depth_q == '0);
  assign overflow = err_q;
  assign pop_data = empty ? '0 : mem[AW'(depth_q - DW'(1))];

  always_ff @(posedge clk) begin
    if (push && !full) mem[AW'(depth_q)] <= push_data;
  end

  always_comb begin
    depth_d = depth_q;
    err_d   = err_q;
    if (push) begin
      if (full) err_d = 1'b1;
      else      depth_d = depth_q + DW'(1);
    end else if (pop && !empty) begin
      depth_d = depth_q - DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      err_q   <= 1'b0;
    end else begin
      depth_q <= depth_d;
      err_q   <= err_d;
    end
  end

  assert_depth_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DW'(DEPTH));
  assert_no_overflow_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> $stable(depth_q));
  assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> overflow);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> $stable(depth_q));
endmodule

// File: rtl/xsc_nav_step.sv
// Combinational axis step: which segments match this tag and which are
// enabled for the children of this tag.
module xsc_nav_step #(
  parameter int NSEG = 8
) (
  input  logic [NSEG-1:0] en_cur,
  input  logic [NSEG-1:0] hit,
  input  logic [NSEG-1:0] axis_desc,
  input  logic [NSEG-1:0] seg_mask,
  output logic [NSEG-1:0] match,
  output logic [NSEG-1:0] en_next
);
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign match[g] = en_cur[g] & hit[g] & seg_mask[g];
    if (g == 0) begin : g_first
      assign en_next[g] = seg_mask[g] & axis_desc[g] & en_cur[g];
    end else begin : g_rest
      assign en_next[g] = seg_mask[g] & (match[g-1] | (axis_desc[g] & en_cur[g]));
    end
  end
endmodule

// File: rtl/xpath_seg_chain.sv
module xpath_seg_chain
  import xsc_pkg::*;
#(
  parameter int NSEG        = 8,
  parameter int NAME_LEN    = 16,
  parameter int STACK_DEPTH = 16,
  parameter int CHAR_W      = 8,
  localparam int SEG_W      = $clog2(NSEG),
  localparam int CNT_W      = $clog2(NSEG + 1),
  localparam int AW         = $clog2(NAME_LEN),
  localparam int IW         = $clog2(NAME_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic [CHAR_W-1:0] tok_char,
  input  logic              cfg_char_we,
  input  logic              cfg_hdr_we,
  input  logic              cfg_cnt_we,
  input  logic [SEG_W-1:0]  cfg_seg,
  input  logic [AW-1:0]     cfg_idx,
  input  logic [CHAR_W-1:0] cfg_char,
  input  logic [IW-1:0]     cfg_len,
  input  logic              cfg_axis,
  input  logic [CNT_W-1:0]  cfg_cnt,
  output logic [NSEG-1:0]   local_match,
  output logic              global_match,
  output logic              stack_err
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  // token decode
  logic tk_start, tk_char, tk_open, tk_close;
  always_comb begin
    tk_start = tok_valid && (tok_kind == TK_NAME_START);
    tk_char  = tok_valid && (tok_kind == TK_NAME_CHAR);
    tk_open  = tok_valid && (tok_kind == TK_OPEN_END);
    tk_close = tok_valid && (tok_kind == TK_CLOSE);
  end

  logic [IW-1:0]    ci_q, ci_d;
  logic [NSEG-1:0]  en_q, en_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NSEG-1:0]  lm_q, lm_d;
  logic             gm_q, gm_d;
  logic [NSEG-1:0]  hit, axis_v, seg_mask, last_sel, match, en_next;
  logic [NSEG-1:0]  pop_data;
  logic             stk_full, stk_empty, stk_err;

  // one node test per segment
  for (genvar g = 0; g < NSEG; g++) begin : g_nt
    xsc_node_test #(.NAME_LEN(NAME_LEN), .CHAR_W(CHAR_W)) u_nt (
      .clk        (clk),
      .rst_n      (rst_q),
      .cfg_char_we(cfg_char_we && (cfg_seg == SEG_W'(g))),
      .cfg_idx    (cfg_idx),
      .cfg_char   (cfg_char),
      .cfg_hdr_we (cfg_hdr_we && (cfg_seg == SEG_W'(g))),
      .cfg_len    (cfg_len),
      .cfg_axis   (cfg_axis),
      .tok_start  (tk_start),
      .tok_char_v (tk_char),
      .tok_char   (tok_char),
      .char_idx   (ci_q),
      .name_hit   (hit[g]),
      .axis       (axis_v[g])
    );
  end

  // active-segment mask and last-segment select from the count
  always_comb begin
    for (int i = 0; i < NSEG; i++) begin
      seg_mask[i] = (CNT_W'(i) < cnt_q);
      last_sel[i] = (cnt_q == CNT_W'(i + 1));
    end
  end

  xsc_nav_step #(.NSEG(NSEG)) u_nav (
    .en_cur   (en_q),
    .hit      (hit),
    .axis_desc(axis_v),
    .seg_mask (seg_mask),
    .match    (match),
    .en_next  (en_next)
  );

  xsc_tag_stack #(.WIDTH(NSEG), .DEPTH(STACK_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_q),
    .push     (tk_open),
    .pop      (tk_close),
    .push_data(en_q),
    .pop_data (pop_data),
    .full     (stk_full),
    .empty    (stk_empty),
    .overflow (stk_err)
  );

  // next state
  always_comb begin
    ci_d  = ci_q;
    en_d  = en_q;
    cnt_d = cnt_q;
    lm_d  = '0;
    gm_d  = 1'b0;
    if (tk_start) begin
      ci_d = '0;
    end else if (tk_char && (ci_q != IW'(NAME_LEN))) begin
      ci_d = ci_q + IW'(1);
    end
    if (tk_open) begin
      lm_d = match;
      gm_d = |(match & last_sel);
      if (!stk_full) en_d = en_next;
    end else if (tk_close && !stk_empty) begin
      en_d = pop_data;
    end
    if (cfg_cnt_we) cnt_d = cfg_cnt;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ci_q  <= '0;
      en_q  <= NSEG'(1);
      cnt_q <= '0;
      lm_q  <= '0;
      gm_q  <= 1'b0;
    end else begin
      ci_q  <= ci_d;
      en_q  <= en_d;
      cnt_q <= cnt_d;
      lm_q  <= lm_d;
      gm_q  <= gm_d;
    end
  end

  assign local_match  = lm_q;
  assign global_match = gm_q;
  assign stack_err    = stk_err;

  assert_local_after_open_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (|local_match) |-> $past(tk_open));
  assert_local_in_range_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (|local_match) |-> ((local_match & ~$past(seg_mask)) == '0));
  assert_global_after_open_R7: assert property (@(posedge clk) disable iff (!rst_q)
    global_match |-> $past(tk_open));
  assert_global_has_local_R7: assert property (@(posedge clk) disable iff (!rst_q)
    global_match |-> (|local_match));
  assert_close_empty_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (tk_close && stk_empty) |=> $stable(en_q));
endmodule

// File: tb/xpath_seg_chain_tb_top.sv
`timescale 1ns/1ps
module xpath_seg_chain_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tok_valid;
  logic [1:0] tok_kind;
  logic [7:0] tok_char;
  logic       cfg_char_we, cfg_hdr_we, cfg_cnt_we;
  logic [2:0] cfg_seg;
  logic [3:0] cfg_idx;
  logic [7:0] cfg_char;
  logic [4:0] cfg_len;
  logic       cfg_axis;
  logic [3:0] cfg_cnt;
  logic [7:0] local_match;
  logic       global_match;
  logic       stack_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [8:0] mon_exp;
  string      mon_tag;

  always #2 clk = ~clk;  // 250 MHz

  xpath_seg_chain dut_i (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .tok_char(tok_char), .cfg_char_we(cfg_char_we), .cfg_hdr_we(cfg_hdr_we),
    .cfg_cnt_we(cfg_cnt_we), .cfg_seg(cfg_seg), .cfg_idx(cfg_idx),
    .cfg_char(cfg_char), .cfg_len(cfg_len), .cfg_axis(cfg_axis),
    .cfg_cnt(cfg_cnt), .local_match(local_match), .global_match(global_match),
    .stack_err(stack_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per consumed token
  always @(posedge clk) begin
    if (tok_valid && rst_n) begin
      #1;
      if (exp_q.size() == 0) begin
        chk("R6 unexpected token result", 1, 0);
      end else begin
        mon_exp = exp_q.pop_front();
        mon_tag = tag_q.pop_front();
        chk(mon_tag, {23'd0, global_match, local_match}, {23'd0, mon_exp});
      end
    end
  end

  // driver
  task automatic send(input logic [1:0] k, input logic [7:0] c,
                      input logic [8:0] e, input string tag);
    @(negedge clk);
    tok_valid = 1'b1;
    tok_kind  = k;
    tok_char  = c;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    tok_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic open_tag(input string s, input logic [7:0] el, input logic eg,
                          input string tag);
    send(2'd0, 8'd0, 9'd0, tag);
    for (int i = 0; i < s.len(); i++) send(2'd1, s[i], 9'd0, tag);
    send(2'd2, 8'd0, {eg, el}, tag);
  endtask

  task automatic close_tag(input int n, input string tag);
    for (int i = 0; i < n; i++) send(2'd3, 8'd0, 9'd0, tag);
  endtask

  task automatic cfg_name(input int seg, input string s, input logic ax);
    for (int i = 0; i < s.len(); i++) begin
      @(negedge clk);
      tok_valid   = 1'b0;
      cfg_char_we = 1'b1;
      cfg_seg     = 3'(seg);
      cfg_idx     = 4'(i);
      cfg_char    = s[i];
    end
    @(negedge clk);
    tok_valid   = 1'b0;
    cfg_char_we = 1'b0;
    cfg_hdr_we  = 1'b1;
    cfg_seg     = 3'(seg);
    cfg_len     = 5'(s.len());
    cfg_axis    = ax;
    @(negedge clk);
    cfg_hdr_we = 1'b0;
  endtask

  task automatic cfg_len0(input int seg);
    @(negedge clk);
    tok_valid  = 1'b0;
    cfg_hdr_we = 1'b1;
    cfg_seg    = 3'(seg);
    cfg_len    = 5'd0;
    cfg_axis   = 1'b1;
    @(negedge clk);
    cfg_hdr_we = 1'b0;
  endtask

  task automatic cfg_count(input int n);
    @(negedge clk);
    tok_valid  = 1'b0;
    cfg_cnt_we = 1'b1;
    cfg_cnt    = 4'(n);
    @(negedge clk);
    cfg_cnt_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset local_match", {24'd0, local_match}, 0);
    chk("R1 reset global_match", {31'd0, global_match}, 0);
    chk("R1 reset stack_err", {31'd0, stack_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tok_valid = 1'b0; tok_kind = 2'd0; tok_char = 8'd0;
    cfg_char_we = 1'b0; cfg_hdr_we = 1'b0; cfg_cnt_we = 1'b0;
    cfg_seg = '0; cfg_idx = '0; cfg_char = '0; cfg_len = '0; cfg_axis = 1'b0; cfg_cnt = '0;
    do_reset();

    // query //a/b/c//d, count not yet written: nothing matches (R1)
    cfg_name(0, "a", 1'b1);
    cfg_name(1, "b", 1'b0);
    cfg_name(2, "c", 1'b0);
    cfg_name(3, "d", 1'b1);
    open_tag("a", 8'h00, 1'b0, "R1 count zero after reset");
    close_tag(1, "R1 close");
    idle(1);
    cfg_count(4);

    // main path, descendant d below x and below another d (R4 R5 R6 R7)
    open_tag("a", 8'h01, 1'b0, "R6 a matches seg0");
    open_tag("b", 8'h02, 1'b0, "R4 b child of a");
    open_tag("c", 8'h04, 1'b0, "R4 c child of b");
    open_tag("x", 8'h00, 1'b0, "R6 x matches none");
    open_tag("d", 8'h08, 1'b1, "R7 d descendant global");
    open_tag("d", 8'h08, 1'b1, "R5 nested d global");
    close_tag(6, "R8 close");
    // no a above: nothing (R4)
    open_tag("b", 8'h00, 1'b0, "R4 b without a");
    open_tag("c", 8'h00, 1'b0, "R4 c without a");
    open_tag("d", 8'h00, 1'b0, "R4 d without a");
    close_tag(3, "R8 close");
    // intervening element breaks child axis (R4)
    open_tag("a", 8'h01, 1'b0, "R4 a");
    open_tag("x", 8'h00, 1'b0, "R4 x");
    open_tag("b", 8'h00, 1'b0, "R4 b grandchild rejected");
    close_tag(3, "R8 close");
    // descendant first segment deep (R5)
    open_tag("x", 8'h00, 1'b0, "R5 x");
    open_tag("a", 8'h01, 1'b0, "R5 a at depth 2");
    open_tag("b", 8'h02, 1'b0, "R5 b under deep a");
    close_tag(3, "R8 close");
    // recursion with restore (R8)
    open_tag("a", 8'h01, 1'b0, "R8 outer a");
    open_tag("b", 8'h02, 1'b0, "R8 outer b");
    open_tag("a", 8'h01, 1'b0, "R8 inner a");
    open_tag("b", 8'h02, 1'b0, "R8 inner b");
    close_tag(2, "R8 close inner");
    open_tag("c", 8'h04, 1'b0, "R8 c after restore");
    open_tag("d", 8'h08, 1'b1, "R8 d after restore");
    close_tag(4, "R8 close");
    idle(1);

    // runtime rename, exact length (R2 R3)
    cfg_name(0, "item", 1'b1);
    cfg_count(1);
    open_tag("ite", 8'h00, 1'b0, "R3 short name");
    close_tag(1, "R3 close");
    open_tag("items", 8'h00, 1'b0, "R3 long name");
    close_tag(1, "R3 close");
    open_tag("a", 8'h00, 1'b0, "R2 old name gone");
    close_tag(1, "R2 close");
    open_tag("item", 8'h01, 1'b1, "R2 new name matches");
    close_tag(1, "R3 close");
    idle(1);
    cfg_len0(0);
    open_tag("", 8'h00, 1'b0, "R3 length zero never matches");
    close_tag(1, "R3 close");
    idle(1);
    cfg_name(0, "abcdefghijklmnop", 1'b1);
    open_tag("abcdefghijklmnop", 8'h01, 1'b1, "R3 16 char name");
    open_tag("abcdefghijklmnopq", 8'h00, 1'b0, "R3 17 char name");
    close_tag(2, "R3 close");
    idle(1);

    // child axis at root, two-segment query (R4 R7)
    cfg_name(0, "a", 1'b0);
    cfg_name(1, "b", 1'b0);
    cfg_count(2);
    open_tag("a", 8'h01, 1'b0, "R4 root child a");
    open_tag("b", 8'h02, 1'b1, "R7 length two global");
    close_tag(2, "R8 close");
    open_tag("z", 8'h00, 1'b0, "R4 z");
    open_tag("a", 8'h00, 1'b0, "R4 a not at root");
    close_tag(2, "R8 close");
    // extra closes at depth zero ignored (R10)
    close_tag(2, "R10 close at depth zero");
    open_tag("a", 8'h01, 1'b0, "R10 root state kept");
    close_tag(1, "R10 close");
    idle(2);

    // overflow (R9)
    cfg_count(0);
    for (int i = 0; i < 16; i++) open_tag("q", 8'h00, 1'b0, "R9 fill");
    idle(2);
    chk("R9 no error at full depth", {31'd0, stack_err}, 0);
    open_tag("q", 8'h00, 1'b0, "R9 overflow tag");
    idle(2);
    chk("R9 error set on overflow", {31'd0, stack_err}, 1);
    close_tag(17, "R9 close");
    idle(2);
    chk("R9 error sticky", {31'd0, stack_err}, 1);
    do_reset();
    chk("R1 error cleared by reset", {31'd0, stack_err}, 0);

    idle(2);
    chk("R6 all results observed", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule